// File: doc/BRIEF.md
# SHA-224/SHA-256 Block Compression Engine

This block is a register-mapped engine that performs the SHA-2 compression function over one 512-bit message block per command. A host writes sixteen 32-bit message words, selects SHA-224 or SHA-256 through a mode register, and issues one of two commands. The first command reloads the standard initial hash values of the chosen mode before compressing. The second command chains from whatever the eight hash state registers hold. The host polls a busy flag and then reads the digest from the state registers. Padding and length encoding are left entirely to host software.

The hash state registers are writable while the engine is idle. An intermediate hash can therefore be read out, replaced by another computation, and later written back and resumed. The message registers are not cleared by a compression, so a word the host does not rewrite carries into the next block. One round is performed per clock, followed by one cycle that adds the working variables into the state.

Top module: `sha2_block_engine`

## Requirements
- R1: The mode register (word address 0x00, bits [2:0], reset value 0) selects the algorithm: 1 is SHA-224, 2 is SHA-256. With any other value, start and continue commands are ignored: busy stays 0 and the hash state is unchanged.
- R2: Writing a word with bit 0 set to the start address (0x01) loads the initial hash values of the selected mode into the state and compresses the message buffer.
- R3: Writing a word with bit 0 set to the continue address (0x02) compresses the message buffer using the current hash state as the chaining input, so a multi-block message yields the chained digest.
- R4: Busy (bit 0 of word address 0x03) reads 1 for exactly 65 clock cycles, starting at the first clock edge after an accepted command, and then reads 0.
- R5: The sixteen message words (word addresses 0x10 to 0x1F, word i at 0x10+i) are readable and keep their contents across a compression. A second continue without rewriting them compresses the same block again.
- R6: A write to a message or hash state word with a byte strobe other than 4'hF is ignored.
- R7: While busy is 1, every register write and command is ignored. The computation in progress, the message words, the hash state and the mode register are left undisturbed.
- R8: The eight hash state words (word addresses 0x20 to 0x27, word i at 0x20+i) are readable and writable while idle. Writing back a saved intermediate state and issuing continue gives the same result as an uninterrupted chain.
- R9: In SHA-224 mode, the SHA-224 initial values are used. State words 0 to 6 form the digest, and word 7 holds the full internal eighth chaining word.
- R10: Words are big-endian: the first message byte is bits [31:24] of message word 0, and the first digest byte is bits [31:24] of state word 0.
- R11: After reset, busy, mode, all message words and all hash state words read 0. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write enable for the current bus cycle |
| bus_addr | input | 6 | Word address of the access |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte strobes for the write |
| bus_rdata | output | 32 | Combinational read data for bus_addr |

## Verification
A fault in the round datapath or in the schedule window corrupts every digest word. This shows up in the first state read after busy falls, which is 66 cycles after the command. A wrong chaining choice, such as reloading the initial values on continue or losing the message words, passes single-block digests but breaks the two-block, repeated-block and save-and-restore digests. A decode that lets writes through while busy, or that accepts partial strobes, shows up as a changed digest or a changed read-back on the very next read.

// File: rtl/sha2_eng_pkg.sv
package sha2_eng_pkg;

   localparam int WORD_W = 32;
   localparam int MODE_W = 3;
   localparam logic [MODE_W-1:0] MODE_224 = 3'd1;
   localparam logic [MODE_W-1:0] MODE_256 = 3'd2;

   typedef logic [WORD_W-1:0] word_t;
   typedef logic [7:0][WORD_W-1:0] hstate_t;

   localparam word_t RC_TAB [64] = '{
      32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
      32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
      32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
      32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
      32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
      32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
      32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
      32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
   };

   function automatic word_t round_const(input logic [5:0] idx);
      return RC_TAB[idx];
   endfunction

   function automatic hstate_t init_vec(input logic [MODE_W-1:0] mode);
      hstate_t v;
      if (mode == MODE_224) begin
         v[0] = 32'hc1059ed8; v[1] = 32'h367cd507; v[2] = 32'h3070dd17; v[3] = 32'hf70e5939;
         v[4] = 32'hffc00b31; v[5] = 32'h68581511; v[6] = 32'h64f98fa7; v[7] = 32'hbefa4fa4;
      end else begin
         v[0] = 32'h6a09e667; v[1] = 32'hbb67ae85; v[2] = 32'h3c6ef372; v[3] = 32'ha54ff53a;
         v[4] = 32'h510e527f; v[5] = 32'h9b05688c; v[6] = 32'h1f83d9ab; v[7] = 32'h5be0cd19;
      end
      return v;
   endfunction

   function automatic word_t rotr(input word_t x, input int n);
      return (x >> n) | (x << (WORD_W - n));
   endfunction

   function automatic word_t sum_a(input word_t x);
      return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
   endfunction

   function automatic word_t sum_e(input word_t x);
      return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
   endfunction

   function automatic word_t mix_lo(input word_t x);
      return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
   endfunction

   function automatic word_t mix_hi(input word_t x);
      return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
   endfunction

endpackage

// File: rtl/sha2_msg_buf.sv
module sha2_msg_buf
   import sha2_eng_pkg::*;
#(
   parameter int WORDS = 16,
   localparam int IDX_W = $clog2(WORDS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [IDX_W-1:0]        wr_idx,
   input  word_t                   wr_data,
   output logic [WORDS-1:0][WORD_W-1:0] msg_q
);

   for (genvar i = 0; i < WORDS; i++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            msg_q[i] <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(i))) begin
            msg_q[i] <= wr_data;
         end
      end
   end

endmodule

// File: rtl/sha2_state_regs.sv
module sha2_state_regs
   import sha2_eng_pkg::*;
#(
   parameter int WORDS = 8,
   localparam int IDX_W = $clog2(WORDS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [IDX_W-1:0]        wr_idx,
   input  word_t                   wr_data,
   input  logic                    iv_load,
   input  logic [WORDS-1:0][WORD_W-1:0] iv_val,
   input  logic                    fold_en,
   input  logic [WORDS-1:0][WORD_W-1:0] work_in,
   output logic [WORDS-1:0][WORD_W-1:0] state_q
);

   for (genvar i = 0; i < WORDS; i++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            state_q[i] <= '0;
         end else if (iv_load) begin
            state_q[i] <= iv_val[i];
         end else if (fold_en) begin
            state_q[i] <= state_q[i] + work_in[i];
         end else if (wr_en && (wr_idx == IDX_W'(i))) begin
            state_q[i] <= wr_data;
         end
      end
   end

endmodule

// File: rtl/sha2_compress.sv
module sha2_compress
   import sha2_eng_pkg::*;
#(
   parameter int ROUNDS      = 64,
   parameter int MSG_WORDS   = 16,
   parameter int STATE_WORDS = 8,
   localparam int CNT_W      = $clog2(ROUNDS)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          go,
   input  logic [STATE_WORDS-1:0][WORD_W-1:0] chain_in,
   input  logic [MSG_WORDS-1:0][WORD_W-1:0]   msg_in,
   output logic                          busy,
   output logic                          fold,
   output logic [STATE_WORDS-1:0][WORD_W-1:0] work_q
);

   typedef enum logic [1:0] {PH_IDLE, PH_ROUND, PH_FOLD} phase_t;

   localparam logic [CNT_W-1:0] LAST_RND = CNT_W'(ROUNDS - 1);

   phase_t                         phase_q;
   logic [CNT_W-1:0]               rnd_q;
   logic [MSG_WORDS-1:0][WORD_W-1:0] win_q;

   word_t t1, t2, w_new;
   logic [STATE_WORDS-1:0][WORD_W-1:0] work_nx;

   always_comb begin
      t1 = work_q[7] + sum_e(work_q[4]) + ((work_q[4] & work_q[5]) ^ (~work_q[4] & work_q[6]))
           + round_const(6'(rnd_q)) + win_q[0];
      t2 = sum_a(work_q[0]) + ((work_q[0] & work_q[1]) ^ (work_q[0] & work_q[2]) ^ (work_q[1] & work_q[2]));
      w_new = mix_hi(win_q[14]) + win_q[9] + mix_lo(win_q[1]) + win_q[0];
      work_nx    = work_q;
      work_nx[7] = work_q[6];
      work_nx[6] = work_q[5];
      work_nx[5] = work_q[4];
      work_nx[4] = work_q[3] + t1;
      work_nx[3] = work_q[2];
      work_nx[2] = work_q[1];
      work_nx[1] = work_q[0];
      work_nx[0] = t1 + t2;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         rnd_q   <= '0;
      end else begin
         unique case (phase_q)
            PH_IDLE: if (go) begin
               phase_q <= PH_ROUND;
               rnd_q   <= '0;
            end
            PH_ROUND: begin
               rnd_q <= rnd_q + 1'b1;
               if (rnd_q == LAST_RND) phase_q <= PH_FOLD;
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         work_q <= '0;
      end else if (phase_q == PH_IDLE && go) begin
         work_q <= chain_in;
      end else if (phase_q == PH_ROUND) begin
         work_q <= work_nx;
      end
   end

   for (genvar i = 0; i < MSG_WORDS; i++) begin : g_win
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            win_q[i] <= '0;
         end else if (phase_q == PH_IDLE && go) begin
            win_q[i] <= msg_in[i];
         end else if (phase_q == PH_ROUND) begin
            if (i == MSG_WORDS - 1) win_q[i] <= w_new;
            else                    win_q[i] <= win_q[(i + 1) % MSG_WORDS];
         end
      end
   end

   assign busy = (phase_q != PH_IDLE);
   assign fold = (phase_q == PH_FOLD);

   AST_ROUND_PHASE_CNT: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_FOLD) |-> (rnd_q == '0)); // R4

endmodule

// File: rtl/sha2_block_engine.sv
module sha2_block_engine
   import sha2_eng_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int MSG_WORDS   = 16,
   parameter int STATE_WORDS = 8,
   parameter int ROUNDS      = 64,
   parameter int MSG_BASE    = 16,
   parameter int STATE_BASE  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WORD_W-1:0] bus_wdata,
   input  logic [3:0]        bus_be,
   output logic [WORD_W-1:0] bus_rdata
);

   localparam int MIDX_W = $clog2(MSG_WORDS);
   localparam int SIDX_W = $clog2(STATE_WORDS);
   localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_START = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_CONT  = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] A_BUSY  = ADDR_W'(3);
   localparam logic [ADDR_W-1:0] A_MSG_LO = ADDR_W'(MSG_BASE);
   localparam logic [ADDR_W-1:0] A_MSG_HI = ADDR_W'(MSG_BASE + MSG_WORDS - 1);
   localparam logic [ADDR_W-1:0] A_ST_LO  = ADDR_W'(STATE_BASE);
   localparam logic [ADDR_W-1:0] A_ST_HI  = ADDR_W'(STATE_BASE + STATE_WORDS - 1);
   localparam int BCNT_W = $clog2(ROUNDS + 3);
   localparam logic [BCNT_W-1:0] BUSY_CYCLES = BCNT_W'(ROUNDS + 1);

   if (ROUNDS != 64)                       begin : g_bad_rounds $error("round count must be 64"); end
   if (MSG_WORDS != 16)                    begin : g_bad_msg    $error("message must be 16 words"); end
   if (STATE_WORDS != 8)                   begin : g_bad_state  $error("state must be 8 words"); end
   if (MSG_BASE % MSG_WORDS != 0)          begin : g_bad_mbase  $error("message base must be aligned"); end
   if (STATE_BASE % STATE_WORDS != 0)      begin : g_bad_sbase  $error("state base must be aligned"); end
   if (STATE_BASE + STATE_WORDS > (1 << ADDR_W)) begin : g_bad_aw $error("address width too small"); end

   logic [MODE_W-1:0] mode_q;
   logic busy, fold;
   logic [MSG_WORDS-1:0][WORD_W-1:0]   msg_q;
   logic [STATE_WORDS-1:0][WORD_W-1:0] state_q, work_q, iv_vec, chain_in;

   logic idle, full_be, msg_hit, st_hit, mode_ok;
   logic start_req, cont_req, go, iv_load, msg_wr, st_wr, mode_wr;

   assign idle      = !busy;
   assign full_be   = &bus_be;
   assign msg_hit   = (bus_addr >= A_MSG_LO) && (bus_addr <= A_MSG_HI);
   assign st_hit    = (bus_addr >= A_ST_LO) && (bus_addr <= A_ST_HI);
   assign mode_ok   = (mode_q == MODE_224) || (mode_q == MODE_256);
   assign start_req = bus_we && (bus_addr == A_START) && bus_wdata[0];
   assign cont_req  = bus_we && (bus_addr == A_CONT) && bus_wdata[0];
   assign go        = idle && mode_ok && (start_req || cont_req);
   assign iv_load   = go && start_req;
   assign msg_wr    = bus_we && idle && full_be && msg_hit;
   assign st_wr     = bus_we && idle && full_be && st_hit;
   assign mode_wr   = bus_we && idle && bus_be[0] && (bus_addr == A_MODE);
   assign iv_vec    = init_vec(mode_q);
   assign chain_in  = start_req ? iv_vec : state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= '0;
      else if (mode_wr) mode_q <= bus_wdata[MODE_W-1:0];
   end

   sha2_msg_buf #(.WORDS(MSG_WORDS)) msg_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (msg_wr),
      .wr_idx  (bus_addr[MIDX_W-1:0]),
      .wr_data (bus_wdata),
      .msg_q   (msg_q)
   );

   sha2_state_regs #(.WORDS(STATE_WORDS)) state_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (st_wr),
      .wr_idx  (bus_addr[SIDX_W-1:0]),
      .wr_data (bus_wdata),
      .iv_load (iv_load),
      .iv_val  (iv_vec),
      .fold_en (fold),
      .work_in (work_q),
      .state_q (state_q)
   );

   sha2_compress #(.ROUNDS(ROUNDS), .MSG_WORDS(MSG_WORDS), .STATE_WORDS(STATE_WORDS)) core_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (go),
      .chain_in (chain_in),
      .msg_in   (msg_q),
      .busy     (busy),
      .fold     (fold),
      .work_q   (work_q)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_MODE)      bus_rdata[MODE_W-1:0] = mode_q;
      else if (bus_addr == A_BUSY) bus_rdata[0] = busy;
      else if (msg_hit)            bus_rdata = msg_q[bus_addr[MIDX_W-1:0]];
      else if (st_hit)             bus_rdata = state_q[bus_addr[SIDX_W-1:0]];
   end

   // busy-length window counter for the checks below
   logic [BCNT_W-1:0] busy_cyc;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_cyc <= '0;
      else if (busy) busy_cyc <= busy_cyc + 1'b1;
      else           busy_cyc <= '0;
   end

   AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_cyc == BUSY_CYCLES)); // R4
   AST_BAD_MODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      ((start_req || cont_req) && !mode_ok && !busy) |=> !busy); // R1
   AST_START_LOADS_IV: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && !busy && mode_ok) |=> (state_q == $past(iv_vec))); // R2
   AST_STATE_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fold) |=> $stable(state_q)); // R7
   AST_MSG_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(msg_q)); // R7
   AST_MSG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $stable(msg_q)); // R5
   AST_PARTIAL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !full_be && msg_hit) |=> $stable(msg_q)); // R6
   AST_MODE_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(mode_q)); // R7

endmodule

// File: tb/sha2_block_engine_tb_top.sv
module sha2_block_engine_tb_top;

   typedef logic [7:0][31:0]  hs_t;
   typedef logic [15:0][31:0] blk_t;

   localparam logic [5:0] A_MODE = 6'h00, A_START = 6'h01, A_CONT = 6'h02, A_BUSY = 6'h03;
   localparam logic [5:0] A_MSG = 6'h10, A_ST = 6'h20;

   localparam logic [31:0] KT [64] = '{
      32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
      32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
      32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
      32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
      32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
      32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
      32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
      32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_we = 1'b0;
   logic [5:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [3:0] bus_be = 4'hF;
   logic [31:0] bus_rdata;

   always #10 clk = ~clk;

   sha2_block_engine dut_i (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic [31:0] act_q[$];

   function automatic logic [31:0] rr(input logic [31:0] x, input int n);
      return (x >> n) | (x << (32 - n));
   endfunction

   function automatic hs_t ref_iv(input bit is224);
      hs_t v;
      if (is224) v = {32'hbefa4fa4, 32'h64f98fa7, 32'h68581511, 32'hffc00b31,
                      32'hf70e5939, 32'h3070dd17, 32'h367cd507, 32'hc1059ed8};
      else       v = {32'h5be0cd19, 32'h1f83d9ab, 32'h9b05688c, 32'h510e527f,
                      32'ha54ff53a, 32'h3c6ef372, 32'hbb67ae85, 32'h6a09e667};
      return v;
   endfunction

   function automatic hs_t ref_comp(input hs_t h, input blk_t m);
      logic [31:0] w [64];
      logic [31:0] a, b, c, d, e, f, g, hh, x1, x2;
      hs_t r;
      for (int t = 0; t < 64; t++) begin
         if (t < 16) w[t] = m[t];
         else w[t] = (rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10)) + w[t-7]
                   + (rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3)) + w[t-16];
      end
      a = h[0]; b = h[1]; c = h[2]; d = h[3]; e = h[4]; f = h[5]; g = h[6]; hh = h[7];
      for (int t = 0; t < 64; t++) begin
         x1 = hh + (rr(e, 6) ^ rr(e, 11) ^ rr(e, 25)) + ((e & f) ^ (~e & g)) + KT[t] + w[t];
         x2 = (rr(a, 2) ^ rr(a, 13) ^ rr(a, 22)) + ((a & b) ^ (a & c) ^ (b & c));
         hh = g; g = f; f = e; e = d + x1; d = c; c = b; b = a; a = x1 + x2;
      end
      r[0] = h[0] + a; r[1] = h[1] + b; r[2] = h[2] + c; r[3] = h[3] + d;
      r[4] = h[4] + e; r[5] = h[5] + f; r[6] = h[6] + g; r[7] = h[7] + hh;
      return r;
   endfunction

   function automatic blk_t mk_blk(input int seed);
      blk_t b;
      for (int i = 0; i < 16; i++) b[i] = (32'h9e3779b9 * (i + 1 + seed * 17)) ^ (32'h01000193 * seed);
      return b;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
      @(negedge clk);
      bus_we = 1'b0; bus_be = 4'hF;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      bus_addr = a;
      #2 d = bus_rdata;
      @(negedge clk);
   endtask

   task automatic load_blk(input blk_t b);
      for (int i = 0; i < 16; i++) wr(A_MSG + 6'(i), b[i]);
   endtask

   task automatic wait_idle(output int cyc);
      logic [31:0] v;
      cyc = 0;
      for (int k = 0; k < 1000; k++) begin
         rd(A_BUSY, v);
         if (v[0] == 1'b0) break;
         cyc++;
      end
   endtask

   // driver side of the scoreboard
   task automatic expect_words(input string tag, input hs_t d, input int nw);
      for (int i = 0; i < nw; i++) begin
         exp_q.push_back(d[i]);
         tag_q.push_back(tag);
      end
   endtask

   task automatic grab_state(input int nw);
      logic [31:0] v;
      for (int i = 0; i < nw; i++) begin
         rd(A_ST + 6'(i), v);
         act_q.push_back(v);
      end
   endtask

   task automatic read_state(output hs_t s);
      logic [31:0] v;
      for (int i = 0; i < 8; i++) begin
         rd(A_ST + 6'(i), v);
         s[i] = v;
      end
   endtask

   // monitor side of the scoreboard
   initial begin
      logic [31:0] a, e;
      string t;
      forever begin
         wait (act_q.size() > 0);
         a = act_q.pop_front();
         n_chk++;
         if (exp_q.size() == 0) begin
            n_err++;
            $display("FAIL scoreboard: unexpected word %h expected none", a);
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (a !== e) begin
               n_err++;
               $display("FAIL %s: digest word got %h expected %h", t, a, e);
            end
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      int cyc;
      hs_t h, s_saved, lit;
      blk_t abc, ba, bb, bc;

      abc = '0;
      abc[0] = 32'h61626380;
      abc[15] = 32'h00000018;
      ba = mk_blk(1); bb = mk_blk(2); bc = mk_blk(3);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset values and unmapped read
      rd(A_MODE, v);       check("R11 mode", v, 32'h0);
      rd(A_BUSY, v);       check("R11 busy", v, 32'h0);
      rd(A_MSG + 6'd7, v); check("R11 msg", v, 32'h0);
      rd(A_ST + 6'd3, v);  check("R11 state", v, 32'h0);
      rd(6'h08, v);        check("R11 unmapped", v, 32'h0);

      // R1 unsupported modes ignore commands
      wr(A_MSG, 32'h12345678);
      wr(A_START, 32'h1);
      rd(A_BUSY, v);      check("R1 mode0 busy", v, 32'h0);
      rd(A_ST, v);        check("R1 mode0 state", v, 32'h0);
      wr(A_MODE, 32'h3);
      wr(A_CONT, 32'h1);
      rd(A_BUSY, v);      check("R1 mode3 busy", v, 32'h0);
      rd(A_MODE, v);      check("R1 mode readback", v, 32'h3);

      // R2 R10 R4 single block SHA-256, known digest
      wr(A_MODE, 32'h2);
      load_blk(abc);
      wr(A_START, 32'h1);
      wait_idle(cyc);
      check("R4 busy cycles", 32'(cyc), 32'd65);
      lit = {32'hf20015ad, 32'hb410ff61, 32'h96177a9c, 32'hb00361a3,
             32'h5dae2223, 32'h414140de, 32'h8f01cfea, 32'hba7816bf};
      expect_words("R10 R2 sha256 one block", lit, 8);
      grab_state(8);

      // R9 SHA-224 on the retained block (R5: no rewrite)
      wr(A_MODE, 32'h1);
      wr(A_START, 32'h1);
      wait_idle(cyc);
      lit = {ref_comp(ref_iv(1), abc)[7], 32'he36c9da7, 32'hbda0b3f7, 32'h2aadbce4,
             32'hbda255b3, 32'h8642a477, 32'h3405d822, 32'h23097d22};
      expect_words("R9 sha224 digest", lit, 8);
      grab_state(8);

      // R3 two-block chain
      wr(A_MODE, 32'h2);
      load_blk(ba);
      wr(A_START, 32'h1);
      wait_idle(cyc);
      load_blk(bb);
      wr(A_CONT, 32'h1);
      wait_idle(cyc);
      h = ref_comp(ref_comp(ref_iv(0), ba), bb);
      expect_words("R3 chained", h, 8);
      grab_state(8);

      // R5 repeat continue without rewriting the block
      wr(A_CONT, 32'h1);
      wait_idle(cyc);
      h = ref_comp(h, bb);
      expect_words("R5 repeat block", h, 8);
      grab_state(8);
      rd(A_MSG + 6'd5, v); check("R5 msg kept", v, bb[5]);

      // R6 partial strobes
      wr(A_MSG + 6'd3, 32'hdeadbeef, 4'b0111);
      rd(A_MSG + 6'd3, v); check("R6 msg partial", v, bb[3]);
      wr(A_ST + 6'd2, 32'hcafef00d, 4'b1110);
      rd(A_ST + 6'd2, v);  check("R6 state partial", v, h[2]);

      // R8 save, disturb, restore and resume
      read_state(s_saved);
      load_blk(bc);
      wr(A_START, 32'h1);
      wait_idle(cyc);
      for (int i = 0; i < 8; i++) wr(A_ST + 6'(i), s_saved[i]);
      rd(A_ST + 6'd6, v);  check("R8 state write", v, s_saved[6]);
      wr(A_CONT, 32'h1);
      wait_idle(cyc);
      expect_words("R8 restored chain", ref_comp(s_saved, bc), 8);
      grab_state(8);

      // R7 writes and commands during busy are ignored
      load_blk(ba);
      wr(A_START, 32'h1);
      wr(A_MSG, 32'h0badf00d);
      wr(A_ST, 32'h11111111);
      wr(A_MODE, 32'h1);
      wr(A_CONT, 32'h1);
      wr(A_START, 32'h1);
      wait_idle(cyc);
      check("R7 busy unaffected", 32'(cyc), 32'd60);
      expect_words("R7 digest undisturbed", ref_comp(ref_iv(0), ba), 8);
      grab_state(8);
      rd(A_MSG, v);  check("R7 msg untouched", v, ba[0]);
      rd(A_MODE, v); check("R7 mode untouched", v, 32'h2);

      wait (act_q.size() == 0);
      #5;
      n_chk++;
      if (exp_q.size() != 0) begin
         n_err++;
         $display("FAIL scoreboard: got %0d leftover expected 0", exp_q.size());
      end
      finish_run();
   end

endmodule